// File: doc/BRIEF.md
# Bus-Attached Parallel Output Port

This block is a memory-mapped output port that hangs on a synchronous processor bus and feeds bytes to a slow parallel device such as a printer. The bus master opens a transfer by raising a cycle strobe together with an address, a read/not-write flag and write data. The port registers these inputs. If the upper address bits match the port's base, a two-state timing machine answers with a one-cycle acknowledge in the third clock period of the transfer. Bit 0 of the address picks one of two registers. When it is 0 the access goes to the output byte. When it is 1 the access goes to a status word that carries a ready flag.

The device side is a valid/ready stream. The ready input is the device's idle line. A data write places the byte on the device pins and raises valid. Valid and the byte stay put until a clock edge at which idle is high; that edge is the handshake. The byte is then taken, valid drops and the ready flag is set. Back-pressure comes only from idle being low, and the byte is never withdrawn while it waits. Software polls the status word before each data write. A write that arrives while a byte is still waiting replaces that byte.

The bus master must hold strobe, address, flag and data until it sees the acknowledge. It must also drop the strobe for at least one clock edge between transfers. An address that does not match gets no acknowledge, and the master's own timeout has to deal with it.

Top module: `par_out_port`

## Requirements
- R1: Only addresses whose bits above bit 0 equal the base address get an acknowledge or change any state; other addresses see no acknowledge and leave device data and valid unchanged.
- R2: For a matching transfer, `bus_ack` is high for exactly one clock period. That period is the third one, counting the period in which `bus_cyc` rises as the first. The acknowledge does not repeat while `bus_cyc` is still held.
- R3: A write with address bit 0 = 0 (`bus_rnw` = 0) drives `bus_wdata` onto `dev_data` and raises `dev_valid` from the clock period after the acknowledge.
- R4: While `dev_valid` is high and `dev_idle` is low, `dev_valid` and `dev_data` stay unchanged. At the first clock edge with `dev_idle` high, the byte is accepted and `dev_valid` is low in the following period.
- R5: A read with address bit 0 = 1 returns the ready flag in bit 1 of `bus_rdata` and zeros in every other bit. The flag is 0 from a data write until that byte is accepted. When no byte is waiting, the flag follows `dev_idle` with one clock of delay.
- R6: A read with address bit 0 = 0 returns the last byte written.
- R7: A write with address bit 0 = 1 is acknowledged but has no effect on `dev_data`, `dev_valid` or the stored byte.
- R8: `bus_rdata` is all zeros in every period in which `bus_ack` is low.
- R9: A synchronous reset clears the stored byte and `dev_valid`, keeps `bus_ack` low, and loads the ready flag from the level of `dev_idle` during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_cyc | input | 1 | Transfer strobe from the bus master |
| bus_rnw | input | 1 | 1 = read, 0 = write |
| bus_addr | input | ADDR_W | Byte address; bit 0 selects data (0) or status (1) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid while `bus_ack` is high, otherwise zero |
| bus_ack | output | 1 | One-cycle acknowledge |
| dev_data | output | DATA_W | Byte presented to the device |
| dev_valid | output | 1 | A byte is waiting for the device |
| dev_idle | input | 1 | Device ready (idle) line |

## Verification
Every byte value from 0 to 255 is written while the device is held busy. Each value is then read back through both registers, released, and read again. This separates the data path, the cleared ready flag and the handshake edge. A sweep flips each address bit above bit 0 in turn, and each flip must lose the acknowledge and leave the device pins alone. This shows that the decoder compares every upper bit and ignores bit 0. Holding the strobe past the acknowledge shows that the timing machine does not answer twice. Resets with the idle line at each level, one of them taken while a byte is still pending, show how the ready flag is seeded and that the pending byte is dropped.

// File: rtl/pop_pkg.sv
package pop_pkg;
  typedef enum logic {
    ST_IDLE    = 1'b0,
    ST_RESPOND = 1'b1
  } pop_state_e;

  localparam logic SEL_DATA   = 1'b0;
  localparam logic SEL_STATUS = 1'b1;
endpackage

// File: rtl/pop_addr_dec.sv
module pop_addr_dec #(
  parameter int unsigned ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
  input  logic [ADDR_W-2:0] addr_hi,
  output logic              hit
);
  localparam logic [ADDR_W-2:0] BASE_HI = BASE_ADDR[ADDR_W-1:1];

  always_comb hit = (addr_hi == BASE_HI);
endmodule

// File: rtl/pop_timing.sv
module pop_timing
  import pop_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_cyc,
  input  logic              bus_rnw,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              hit,
  output logic [ADDR_W-1:0] addr_q,
  output logic              ack,
  output logic              rnw_lat,
  output logic              sel_lat,
  output logic [DATA_W-1:0] wdata_lat,
  output logic              wr_data
);
  logic              cyc_q, cyc_qq, rnw_q;
  logic [DATA_W-1:0] wdata_q;
  pop_state_e        state, state_nx;
  logic              go;

  // Bus inputs are registered first; a fresh strobe edge plus a hit is Go.
  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_q   <= 1'b0;
      cyc_qq  <= 1'b0;
      rnw_q   <= 1'b1;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      cyc_q   <= bus_cyc;
      cyc_qq  <= cyc_q;
      rnw_q   <= bus_rnw;
      addr_q  <= bus_addr;
      wdata_q <= bus_wdata;
    end
  end

  always_comb go = cyc_q & ~cyc_qq & hit & (state == ST_IDLE);

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:    if (go) state_nx = ST_RESPOND;
      ST_RESPOND: state_nx = ST_IDLE;
      default:    state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      rnw_lat   <= 1'b1;
      sel_lat   <= SEL_DATA;
      wdata_lat <= '0;
    end else begin
      state <= state_nx;
      if (go) begin
        rnw_lat   <= rnw_q;
        sel_lat   <= addr_q[0];
        wdata_lat <= wdata_q;
      end
    end
  end

  always_comb begin
    ack     = (state == ST_RESPOND);
    wr_data = ack & ~rnw_lat & (sel_lat == SEL_DATA);
  end
endmodule

// File: rtl/pop_regs.sv
module pop_regs
  import pop_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned RDY_BIT = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_data,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_en,
  input  logic              rd_sel,
  input  logic              dev_idle,
  output logic [DATA_W-1:0] dev_data,
  output logic              dev_valid,
  output logic [DATA_W-1:0] rdata
);
  logic              rdy;
  logic [DATA_W-1:0] status_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      dev_data  <= '0;
      dev_valid <= 1'b0;
      rdy       <= dev_idle;
    end else if (wr_data) begin
      // a new write wins over an acceptance on the same edge
      dev_data  <= wdata;
      dev_valid <= 1'b1;
      rdy       <= 1'b0;
    end else if (dev_valid) begin
      if (dev_idle) begin
        dev_valid <= 1'b0;
        rdy       <= 1'b1;
      end
    end else begin
      rdy <= dev_idle;
    end
  end

  always_comb begin
    status_word          = '0;
    status_word[RDY_BIT] = rdy;
  end

  always_comb begin
    if (!rd_en)                  rdata = '0;
    else if (rd_sel == SEL_DATA) rdata = dev_data;
    else                         rdata = status_word;
  end
endmodule

// File: rtl/par_out_port.sv
module par_out_port #(
  parameter int unsigned       ADDR_W    = 32,
  parameter int unsigned       DATA_W    = 8,
  parameter int unsigned       RDY_BIT   = 1,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h0000_4A10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_cyc,
  input  logic              bus_rnw,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_ack,
  output logic [DATA_W-1:0] dev_data,
  output logic              dev_valid,
  input  logic              dev_idle
);
  logic [ADDR_W-1:0] addr_q;
  logic              hit, rnw_lat, sel_lat, wr_data;
  logic [DATA_W-1:0] wdata_lat;

  pop_addr_dec #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
    .addr_hi (addr_q[ADDR_W-1:1]),
    .hit     (hit)
  );

  pop_timing #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_tim (
    .clk       (clk),
    .rst       (rst),
    .bus_cyc   (bus_cyc),
    .bus_rnw   (bus_rnw),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .hit       (hit),
    .addr_q    (addr_q),
    .ack       (bus_ack),
    .rnw_lat   (rnw_lat),
    .sel_lat   (sel_lat),
    .wdata_lat (wdata_lat),
    .wr_data   (wr_data)
  );

  pop_regs #(.DATA_W(DATA_W), .RDY_BIT(RDY_BIT)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_data   (wr_data),
    .wdata     (wdata_lat),
    .rd_en     (bus_ack & rnw_lat),
    .rd_sel    (sel_lat),
    .dev_idle  (dev_idle),
    .dev_data  (dev_data),
    .dev_valid (dev_valid),
    .rdata     (bus_rdata)
  );
endmodule

// File: rtl/pop_checker.sv
module pop_checker #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_cyc,
  input logic              bus_ack,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [DATA_W-1:0] dev_data,
  input logic              dev_valid,
  input logic              dev_idle,
  input logic              wr_data,
  input logic [DATA_W-1:0] wdata_lat
);
  // R2: acknowledge lasts one period
  p_ack_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    bus_ack |=> !bus_ack);

  // R2: acknowledge falls in the third period after the strobe rose
  p_ack_delay_r2: assert property (@(posedge clk) disable iff (rst)
    bus_ack |-> ($past(bus_cyc, 2) && !$past(bus_cyc, 3)));

  // R3: a data write shows up on the device pins with valid
  p_load_r3: assert property (@(posedge clk) disable iff (rst)
    wr_data |=> (dev_valid && dev_data == $past(wdata_lat)));

  // R4: pending byte held while the device is busy
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (dev_valid && !dev_idle && !wr_data) |=> (dev_valid && $stable(dev_data)));

  // R4: idle high takes the byte
  p_accept_r4: assert property (@(posedge clk) disable iff (rst)
    (dev_valid && dev_idle && !wr_data) |=> !dev_valid);

  // R8: read bus quiet outside the acknowledge
  p_rdata_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !bus_ack |-> (bus_rdata == '0));
endmodule

bind par_out_port pop_checker #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_cyc   (bus_cyc),
  .bus_ack   (bus_ack),
  .bus_rdata (bus_rdata),
  .dev_data  (dev_data),
  .dev_valid (dev_valid),
  .dev_idle  (dev_idle),
  .wr_data   (wr_data),
  .wdata_lat (wdata_lat)
);

// File: tb/test_par_out_port.sv
module test_par_out_port;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned DATA_W = 8;
  localparam logic [31:0] BASE   = 32'h0000_4A10;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_cyc = 1'b0, bus_rnw = 1'b1, dev_idle = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata, dev_data;
  logic              bus_ack, dev_valid;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  par_out_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_ADDR(BASE)) i_par_out_port (
    .clk(clk), .rst(rst), .bus_cyc(bus_cyc), .bus_rnw(bus_rnw), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .dev_data(dev_data), .dev_valid(dev_valid), .dev_idle(dev_idle)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One transfer: acknowledge period, read data and count of acknowledges.
  task automatic xfer(input logic [31:0] a, input logic rnw, input logic [7:0] d,
                      output logic [7:0] rd, output int lat, output int nack);
    @(negedge clk);
    bus_cyc = 1'b1; bus_addr = a; bus_rnw = rnw; bus_wdata = d;
    lat = -1; nack = 0; rd = '0;
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk);
      if (bus_ack) begin
        nack++;
        if (lat < 0) begin lat = i; rd = bus_rdata; end
      end else begin
        check(bus_rdata == '0, "R8 rdata quiet", int'(bus_rdata), 0);
      end
    end
    bus_cyc = 1'b0;
  endtask

  task automatic hit_xfer(input logic [31:0] a, input logic rnw, input logic [7:0] d,
                          output logic [7:0] rd);
    int lat, nack;
    xfer(a, rnw, d, rd, lat, nack);
    check(lat == 2, "R2 ack in third period", lat, 2);
    check(nack == 1, "R2 single ack with strobe held", nack, 1);
  endtask

  task automatic do_reset(input logic lvl);
    logic [7:0] rd;
    @(negedge clk);
    rst = 1'b1; dev_idle = lvl; bus_cyc = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(dev_data == 8'h00, "R9 data cleared", int'(dev_data), 0);
    check(dev_valid == 1'b0, "R9 valid cleared", int'(dev_valid), 0);
    check(bus_ack == 1'b0, "R9 no ack", int'(bus_ack), 0);
    hit_xfer(BASE | 32'd1, 1'b1, 8'h00, rd);
    check(rd == {6'b0, lvl, 1'b0}, "R9 ready from idle", int'(rd), int'({6'b0, lvl, 1'b0}));
  endtask

  initial begin : wdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] rd;
    int lat, nack;

    do_reset(1'b1);
    do_reset(1'b0);

    // R3 R4 R5 R6: every byte value through the full handshake
    for (int v = 0; v < 256; v++) begin
      dev_idle = 1'b0;
      hit_xfer(BASE, 1'b0, v[7:0], rd);
      check(dev_valid == 1'b1, "R3 valid raised", int'(dev_valid), 1);
      check(dev_data == v[7:0], "R3 byte on device", int'(dev_data), v);
      hit_xfer(BASE | 32'd1, 1'b1, 8'h00, rd);
      check(rd == 8'h00, "R5 ready clear while pending", int'(rd), 0);
      check(dev_valid && dev_data == v[7:0], "R4 held while busy", int'(dev_data), v);
      @(negedge clk); dev_idle = 1'b1;
      @(negedge clk);
      check(dev_valid == 1'b0, "R4 accepted on idle", int'(dev_valid), 0);
      hit_xfer(BASE | 32'd1, 1'b1, 8'h00, rd);
      check(rd == 8'h02, "R5 ready after accept", int'(rd), 2);
      hit_xfer(BASE, 1'b1, 8'h00, rd);
      check(rd == v[7:0], "R6 data readback", int'(rd), v);
    end

    // R5: ready follows idle when nothing pending
    @(negedge clk); dev_idle = 1'b0;
    hit_xfer(BASE | 32'd1, 1'b1, 8'h00, rd);
    check(rd == 8'h00, "R5 ready follows idle low", int'(rd), 0);

    // R7: status write ignored
    hit_xfer(BASE | 32'd1, 1'b0, 8'hA5, rd);
    check(dev_valid == 1'b0, "R7 status write no valid", int'(dev_valid), 0);
    check(dev_data == 8'hFF, "R7 status write no data", int'(dev_data), 8'hFF);
    hit_xfer(BASE, 1'b1, 8'h00, rd);
    check(rd == 8'hFF, "R7 stored byte kept", int'(rd), 8'hFF);

    // R1: flip each upper address bit, read and write
    for (int b = 1; b < ADDR_W; b++) begin
      xfer(BASE ^ (32'd1 << b), 1'b1, 8'h00, rd, lat, nack);
      check(nack == 0, "R1 miss read no ack", nack, 0);
      xfer(BASE ^ (32'd1 << b), 1'b0, 8'h3C, rd, lat, nack);
      check(nack == 0, "R1 miss write no ack", nack, 0);
      check(dev_valid == 1'b0 && dev_data == 8'hFF, "R1 miss no effect",
            int'(dev_data), 8'hFF);
    end

    // R9: reset with a byte pending
    hit_xfer(BASE, 1'b0, 8'h77, rd);
    check(dev_valid == 1'b1, "R3 pending before reset", int'(dev_valid), 1);
    do_reset(1'b1);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule